// File: doc/BRIEF.md
# Byte-Rate Serial-to-Parallel Converter

This block turns an aligned serial bit stream into parallel words. The words appear on a byte-rate output clock that runs freely and never changes its shape. Every bit clock, the serial input enters a shift register. An upstream aligner raises a byte-boundary strobe in the cycle that carries the last bit of each aligned word. On that edge, the completed word is copied into an internal holding register. A divide-by-`DW` counter on the bit clock produces the output clock. On the bit clock edge where that output clock falls, an output register takes the holding register's contents and drives the parallel bus.

The output clock ignores the boundary strobe, so a realignment never shortens or stretches it. The price is that latency is not fixed. It floats across one word period, depending on where the boundary strobe sits relative to the output clock's falling edge. When the aligner moves to a new phase, the change in interval between boundary strobes can cost one word or show one word twice. After that, the stream continues in order.

Top module: `byte_deserializer`

## Requirements
- R1: While `rst_n` is low, `par_out` is all zeros and `byte_clk` is high. The clock divider restarts from phase 0 when reset is released.
- R2: Counting bit clock edges since reset release, `byte_clk` is high after c edges when (c mod `DW`) < `DW`/2 and low otherwise. `ser_in` and `byte_mark` have no effect on it.
- R3: Serial bits are taken most significant first. The bit sampled earliest in a word ends up in `par_out[DW-1]`.
- R4: On a bit clock edge with `byte_mark` high, the holding register captures the word whose last bit is on `ser_in` at that edge. Without `byte_mark`, the holding register keeps its value.
- R5: `par_out` changes only on the bit clock edge where `byte_clk` falls. At that edge it takes the holding register value from before the edge.
- R6: Let a word's first bit be sampled on edge s. That word appears on `par_out` after an edge e with `DW` <= e - s <= 2*`DW`-1.
- R7: While strobes stay `DW` edges apart, each aligned word is presented exactly once, in order, with none dropped.
- R8: After a single shift of the strobe phase, at most one word is lost or repeated. The output then follows the new stream in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Recovered bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, most significant bit first |
| byte_mark | input | 1 | High with the last bit of each aligned word |
| par_out | output | DW | Parallel output word |
| byte_clk | output | 1 | Free-running word-rate clock, 50% duty |

## Verification
The bench builds the block with the default `DW` of 8. This keeps the space of alignment phases small enough to sweep completely. All eight strobe phases relative to the output clock are combined with fifteen realignment shifts, from seven bits earlier to seven bits later. This covers both ends of the latency window, the exact drop and repeat cases at a reframe, and the undisturbed run where the shift is zero.

// File: rtl/byte_deserializer.sv
module byte_deserializer #(
  parameter int DW = 8
) (
  input  logic          bit_clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          byte_mark,
  output logic [DW-1:0] par_out,
  output logic          byte_clk
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] HALF    = CW'(DW / 2);
  localparam logic [CW-1:0] FALL_AT = CW'(DW / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic          bclk_q;
  logic [DW-1:0] sr_q, hold_q, out_q;

  wire [CW-1:0] cnt_nx   = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  wire [DW-1:0] word_now = {sr_q[DW-2:0], ser_in};

  // Free-running divider; registered clock output so it cannot glitch.
  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nx;
      bclk_q <= (cnt_nx < HALF);
    end

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) sr_q <= '0;
    else        sr_q <= word_now;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)         hold_q <= '0;
    else if (byte_mark) hold_q <= word_now;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)                 out_q <= '0;
    else if (cnt_q == FALL_AT)  out_q <= hold_q;

  assign par_out  = out_q;
  assign byte_clk = bclk_q;

  // Independent phase reference for the clock-shape check.
  logic [CW-1:0] chk_q;
  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)             chk_q <= '0;
    else if (chk_q == LAST) chk_q <= '0;
    else                    chk_q <= chk_q + CW'(1);

  assert_bclk_shape_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    byte_clk == (chk_q < HALF));

  assert_shift_in_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    1'b1 |=> sr_q[0] == $past(ser_in));

  assert_hold_keep_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !byte_mark |=> $stable(hold_q));

  assert_out_load_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(byte_clk) |-> par_out == $past(hold_q));

  assert_out_hold_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !$fell(byte_clk) |-> $stable(par_out));
endmodule

// File: tb/tb_byte_deserializer.sv
module tb_byte_deserializer;
  localparam int DW = 8;
  localparam int NA = 6;
  localparam int NB = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ser_in = 1'b0, byte_mark = 1'b0;
  logic [DW-1:0] par_out;
  logic byte_clk;

  byte_deserializer #(.DW(DW)) dut (
    .bit_clk(clk), .rst_n(rst_n), .ser_in(ser_in), .byte_mark(byte_mark),
    .par_out(par_out), .byte_clk(byte_clk));

  int n_cmp = 0, n_bad = 0;
  int s1, t2, nA;
  bit finished = 1'b0;

  function automatic logic [7:0] va(int k); return 8'(k * 29 + 5);   endfunction
  function automatic logic [7:0] vb(int k); return 8'(k * 29 + 133); endfunction

  function automatic logic [7:0] gval(int g);
    if (g < 0)  return 8'h00;
    if (g < nA) return va(g);
    return vb(g - nA);
  endfunction

  function automatic int decode(logic [7:0] v);
    for (int k = 0; k < nA; k++) if (va(k) == v) return k;
    for (int k = 0; k < NB; k++) if (vb(k) == v) return nA + k;
    return -1;
  endfunction

  function automatic int exp_g(int e);
    int last = e - 1;
    if (last >= t2 + 7) begin
      int k = (last - t2 - 7) / 8;
      return nA + ((k > NB - 1) ? NB - 1 : k);
    end
    if (nA > 0 && last >= s1 + 7) begin
      int k = (last - s1 - 7) / 8;
      return (k > nA - 1) ? nA - 1 : k;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (s1=%0d t2=%0d)", req, act, exp, s1, t2);
    end
  endtask

  task automatic run(int a, int b);
    int c, prev_g, anomalies;
    logic [DW-1:0] prev_out;
    s1 = a; t2 = b; nA = 0;
    for (int k = 0; k < NA; k++) if (s1 + 8*k + 7 < t2) nA++;
    rst_n = 1'b0; ser_in = 1'b0; byte_mark = 1'b0;
    repeat (3) @(negedge clk);
    check(par_out == '0, "R1 par_out", par_out, 0);
    check(byte_clk == 1'b1, "R1 byte_clk", byte_clk, 1);
    rst_n = 1'b1;
    c = 0; prev_g = -1; anomalies = 0; prev_out = '0;
    while (c < t2 + 8*NB + 24) begin
      if (c >= t2 && c < t2 + 8*NB) begin
        ser_in    = vb((c - t2) / 8)[7 - (c - t2) % 8];
        byte_mark = ((c - t2) % 8 == 7);
      end else if (c >= s1 && c < s1 + 8*NA && c < t2) begin
        ser_in    = va((c - s1) / 8)[7 - (c - s1) % 8];
        byte_mark = ((c - s1) % 8 == 7);
      end else begin
        ser_in = 1'b0; byte_mark = 1'b0;
      end
      @(posedge clk);
      c++;
      @(negedge clk);
      check(byte_clk == ((c % 8) < 4), "R2 byte_clk", byte_clk, (c % 8) < 4);
      if ((c - 1) % 8 == 3) begin
        int e = c - 1;
        int eg = exp_g(e);
        int ag = decode(par_out);
        check(par_out == gval(eg), "R3,R4,R5 word", par_out, gval(eg));
        if (ag >= 0 && ag < nA && e < t2)
          check((e - (s1 + 8*ag)) >= 8 && (e - (s1 + 8*ag)) <= 15,
                "R6 latency", e - (s1 + 8*ag), 8);
        if (ag >= 0 && prev_g >= 0 && e < t2 + 8*NB && ag != prev_g + 1)
          anomalies++;
        if (ag >= 0) prev_g = ag;
      end else begin
        check(par_out == prev_out, "R5 stable", par_out, prev_out);
      end
      prev_out = par_out;
    end
    if (t2 == s1 + 8*NA)
      check(anomalies == 0, "R7 no drop/dup", anomalies, 0);
    else
      check(anomalies <= 1, "R8 reframe slip", anomalies, 1);
  endtask

  initial begin
    for (int p = 0; p < 8; p++)
      for (int d = -7; d <= 7; d++)
        run(p, p + 8*NA + d);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule